// File: doc/BRIEF.md
# Mandelbrot Escape-Time Iteration Engine

This block computes the escape count of a single complex point c, the value an image generator uses as the colour of one pixel. Starting from z = 0, it applies z = z*z + c again and again in signed fixed point. It stops as soon as the squared magnitude of z reaches 4, or when the iteration count reaches a limit supplied with the request. The count at that moment is the result.

Each iteration needs the value of z produced by the one before it, so the engine keeps exactly one iteration in flight. It splits that iteration into two clock cycles. In the first, three registered products are formed. In the second, the escape test runs and z is updated. The run time therefore depends on the point. A host raises `start_i` while the engine is idle, waits for the one-cycle `done_o` pulse and reads `count_o`.

Both components of c are expected to lie within [-2.0, 2.0]. This keeps every intermediate value of a point that has not yet escaped inside the number format.

Top module: `mandel_escape_engine`

## Requirements
- R1: While reset is high, and in the cycle after it, busy_o is 0, done_o is 0 and count_o is 0.
- R2: start_i is accepted only on a clock edge where busy_o is 0. busy_o is 1 from the next cycle until the run ends. A start_i seen while busy_o is 1 has no effect on the run in progress or on its result.
- R3: Numbers are signed Q4.28 two's complement, so 1.0 is 0x1000_0000. Each product is rounded half-up: add 2^27, then shift right arithmetically by 28. A run starts with z = 0+0i and n = 0. Each iteration sets z to z*z + c and adds one to n.
- R4: Before each iteration, the engine compares re(z)^2 + im(z)^2, built from the rounded squares, against 4.0. A value equal to or above 4.0 ends the run. For example, c = 2.0 ends with count 1, and c just below 2.0 ends with count 2.
- R5: A run also ends when n equals the limit. A point that never escapes reports exactly the limit, and a limit of 0 reports 0.
- R6: If a run ends with count n, done_o is high for exactly one cycle, 2*(n+1) clock edges after the edge that accepted start_i.
- R7: busy_o is 0 whenever done_o is 1. count_o changes only on the edge that raises done_o and stays stable until the next done_o.
- R8: limit_i is sampled on the accepting edge. Changing it later has no effect on the run, and a reported count never exceeds the sampled limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request a run for the supplied point |
| c_re_i | input | 32 | Real part of c, Q4.28 |
| c_im_i | input | 32 | Imaginary part of c, Q4.28 |
| limit_i | input | 16 | Iteration cap, sampled on acceptance |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when a run ends |
| count_o | output | 16 | Escape count of the last finished run |

## Verification
For every accepted start, the bench works out the escape count n with a fixed-point model built from R3 to R5. It then schedules the done pulse for the edge that lies 2*(n+1) edges after the acceptance edge. The monitor samples at falling edges. It checks that each done pulse arrives at exactly that scheduled edge, with exactly that count, and it flags any pulse that nothing was scheduled for. Busy is checked in the first half cycle after acceptance. A start and a new limit that the driver pokes in while the engine is busy must leave both the count and the timing unchanged.

// File: rtl/mb_pkg.sv
package mb_pkg;

    localparam int W      = 32;
    localparam int FRAC   = 28;
    localparam int CNT_W  = 16;
    localparam int PROD_W = 2 * W - FRAC;
    localparam int MAG_W  = PROD_W + 1;

    typedef logic signed [W-1:0]      fx_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [MAG_W-1:0]  mag_t;
    typedef logic [CNT_W-1:0]         cnt_t;

    typedef struct packed {
        fx_t re;
        fx_t im;
    } cplx_t;

    typedef struct packed {
        prod_t rr;
        prod_t ii;
        prod_t ri;
    } sq_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_UPD  = 2'd2
    } st_e;

    localparam mag_t ESC_MAG = mag_t'(4) <<< FRAC;

    // Full product, round half-up, drop FRAC fraction bits.
    function automatic prod_t fx_mul(input fx_t a, input fx_t b);
        logic signed [2*W-1:0] p;
        logic signed [2*W-1:0] s;
        p = a * b;
        s = (p + (64'sd1 <<< (FRAC - 1))) >>> FRAC;
        return s[PROD_W-1:0];
    endfunction

endpackage

// File: rtl/mb_square_unit.sv
module mb_square_unit
    import mb_pkg::*;
(
    input  logic  clk,
    input  logic  en,
    input  cplx_t z,
    output sq_t   sq
);
    always_ff @(posedge clk) begin
        if (en) begin
            sq.rr <= fx_mul(z.re, z.re);
            sq.ii <= fx_mul(z.im, z.im);
            sq.ri <= fx_mul(z.re, z.im);
        end
    end
endmodule

// File: rtl/mb_step_unit.sv
module mb_step_unit
    import mb_pkg::*;
(
    input  sq_t   sq,
    input  cplx_t c,
    input  cnt_t  cnt,
    input  cnt_t  limit,
    output logic  stop,
    output cplx_t z_next
);
    mag_t  mag;
    prod_t dre;
    prod_t dim;
    logic  escaped;
    logic  capped;

    always_comb begin
        mag     = $signed({sq.rr[PROD_W-1], sq.rr}) + $signed({sq.ii[PROD_W-1], sq.ii});
        escaped = (mag >= ESC_MAG);
        capped  = (cnt == limit);
        stop    = escaped | capped;
        dre     = sq.rr - sq.ii + prod_t'(c.re);
        dim     = (sq.ri <<< 1) + prod_t'(c.im);
        z_next.re = dre[W-1:0];
        z_next.im = dim[W-1:0];
    end
endmodule

// File: rtl/mb_seq_ctrl.sv
module mb_seq_ctrl
    import mb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic stop,
    output logic busy,
    output logic load,
    output logic sq_en,
    output logic adv,
    output logic finish
);
    st_e st_q;
    st_e st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start) st_d = ST_MUL;
            ST_MUL:  st_d = ST_UPD;
            ST_UPD:  st_d = stop ? ST_IDLE : ST_MUL;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign busy   = (st_q != ST_IDLE);
    assign load   = (st_q == ST_IDLE) && start;
    assign sq_en  = (st_q == ST_MUL);
    assign adv    = (st_q == ST_UPD) && !stop;
    assign finish = (st_q == ST_UPD) && stop;
endmodule

// File: rtl/mandel_escape_engine.sv
module mandel_escape_engine
    import mb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [31:0] c_re_i,
    input  logic [31:0] c_im_i,
    input  logic [15:0] limit_i,
    output logic        busy_o,
    output logic        done_o,
    output logic [15:0] count_o
);
    cplx_t z_q;
    cplx_t c_q;
    cplx_t z_next;
    cnt_t  lim_q;
    cnt_t  cnt_q;
    cnt_t  count_q;
    logic  done_q;
    sq_t   sq;
    logic  stop;
    logic  load;
    logic  sq_en;
    logic  adv;
    logic  finish;

    mb_seq_ctrl i_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start_i),
        .stop   (stop),
        .busy   (busy_o),
        .load   (load),
        .sq_en  (sq_en),
        .adv    (adv),
        .finish (finish)
    );

    mb_square_unit i_sq (
        .clk (clk),
        .en  (sq_en),
        .z   (z_q),
        .sq  (sq)
    );

    mb_step_unit i_step (
        .sq     (sq),
        .c      (c_q),
        .cnt    (cnt_q),
        .limit  (lim_q),
        .stop   (stop),
        .z_next (z_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            z_q     <= '0;
            c_q     <= '0;
            lim_q   <= '0;
            cnt_q   <= '0;
            count_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= finish;
            if (load) begin
                c_q.re <= c_re_i;
                c_q.im <= c_im_i;
                lim_q  <= limit_i;
                z_q    <= '0;
                cnt_q  <= '0;
            end
            if (adv) begin
                z_q   <= z_next;
                cnt_q <= cnt_q + cnt_t'(1);
            end
            if (finish) begin
                count_q <= cnt_q;
            end
        end
    end

    assign done_o  = done_q;
    assign count_o = count_q;
endmodule

// File: rtl/mandel_escape_checker.sv
module mandel_escape_checker (
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic        busy_o,
    input logic        done_o,
    input logic [15:0] count_o,
    input logic [15:0] lim_q
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o && count_o == 16'd0));

    assert_start_taken_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_idle_on_done_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    assert_count_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(count_o));

    assert_count_capped_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (count_o <= lim_q));

    assert_limit_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(lim_q));
endmodule

bind mandel_escape_engine mandel_escape_checker i_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .count_o (count_o),
    .lim_q   (lim_q)
);

// File: tb/test_mandel_escape_engine.sv
`timescale 1ns/100ps
module test_mandel_escape_engine;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [31:0] c_re_i;
    logic [31:0] c_im_i;
    logic [15:0] limit_i;
    logic        busy_o;
    logic        done_o;
    logic [15:0] count_o;

    always #2.5 clk = ~clk;

    mandel_escape_engine i_mandel_escape_engine (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .c_re_i  (c_re_i),
        .c_im_i  (c_im_i),
        .limit_i (limit_i),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .count_o (count_o)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        int    cnt;
        int    due;
        string tag;
    } exp_t;
    exp_t q[$];

    function automatic int to_fx(real r);
        return $rtoi(r * 268435456.0);
    endfunction

    function automatic longint rmul(longint a, longint b);
        return (a * b + (longint'(1) <<< 27)) >>> 28;
    endfunction

    // Reference escape count from R3, R4 and R5.
    function automatic int model(int cr, int ci, int lim);
        int zr = 0;
        int zi = 0;
        int n  = 0;
        longint rr;
        longint ii;
        longint ri;
        forever begin
            rr = rmul(zr, zr);
            ii = rmul(zi, zi);
            ri = rmul(zr, zi);
            if (rr + ii >= (longint'(1) <<< 30)) break;
            if (n == lim) break;
            zr = int'(rr - ii + cr);
            zi = int'(2 * ri + ci);
            n++;
        end
        return n;
    endfunction

    // Scoreboard monitor.
    logic [15:0] prev_count = '0;
    logic        prev_done  = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (done_o) begin
                n_cmp++;
                if (prev_done) begin
                    n_bad++;
                    $display("FAIL R6: done high two cycles in a row, actual=1 expected=0");
                end
                if (q.size() == 0) begin
                    n_cmp++;
                    n_bad++;
                    $display("FAIL R2: unexpected done with count %0d, expected no done", count_o);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    n_cmp++;
                    if (count_o != e.cnt[15:0]) begin
                        n_bad++;
                        $display("FAIL %s: count actual=%0d expected=%0d", e.tag, count_o, e.cnt);
                    end
                    if (cyc != e.due) begin
                        n_bad++;
                        $display("FAIL R6 (%s): done at cycle actual=%0d expected=%0d", e.tag, cyc, e.due);
                    end
                end
                if (busy_o) begin
                    n_bad++;
                    $display("FAIL R7: busy during done, actual=1 expected=0");
                end
            end else begin
                n_cmp++;
                if (count_o != prev_count) begin
                    n_bad++;
                    $display("FAIL R7: count changed without done, actual=%0d expected=%0d", count_o, prev_count);
                end
            end
        end
        prev_count = count_o;
        prev_done  = done_o;
    end

    task automatic run_point(input real re, input real im, input int lim, input bit poke, input string tag);
        int k;
        int n;
        @(negedge clk);
        while (busy_o) @(negedge clk);
        c_re_i  = to_fx(re);
        c_im_i  = to_fx(im);
        limit_i = lim[15:0];
        start_i = 1'b1;
        @(posedge clk);
        #1;
        k = cyc;
        n = model(to_fx(re), to_fx(im), lim);
        q.push_back('{n, k + 2 + 2 * n, tag});
        @(negedge clk);
        n_cmp++;
        if (busy_o !== 1'b1) begin
            n_bad++;
            $display("FAIL R2: busy after accept, actual=%b expected=1", busy_o);
        end
        if (poke) begin
            // R2 and R8: a second request and a new limit arrive mid-run.
            c_re_i  = to_fx(1.5);
            c_im_i  = to_fx(1.5);
            limit_i = 16'd3;
            start_i = 1'b1;
            @(negedge clk);
        end
        start_i = 1'b0;
        while (q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst     = 1'b1;
        start_i = 1'b0;
        c_re_i  = '0;
        c_im_i  = '0;
        limit_i = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (busy_o !== 1'b0 || done_o !== 1'b0 || count_o !== 16'd0) begin
            n_bad++;
            $display("FAIL R1: reset state actual=%b/%b/%0d expected=0/0/0", busy_o, done_o, count_o);
        end
        rst = 1'b0;
        @(negedge clk);
        n_cmp++;
        if (busy_o !== 1'b0 || done_o !== 1'b0 || count_o !== 16'd0) begin
            n_bad++;
            $display("FAIL R1: after reset actual=%b/%b/%0d expected=0/0/0", busy_o, done_o, count_o);
        end

        run_point(0.0,    0.0,  20,  1'b0, "R5");
        run_point(0.0,    0.0,  0,   1'b0, "R5");
        run_point(0.0,    0.0,  1,   1'b0, "R5");
        run_point(2.0,    0.0,  10,  1'b0, "R4");
        run_point(-2.0,   0.0,  10,  1'b0, "R4");
        run_point(1.99,   0.0,  10,  1'b0, "R4");
        run_point(1.0,    0.0,  10,  1'b0, "R3");
        run_point(-1.0,   0.0,  40,  1'b0, "R5");
        run_point(0.25,   0.0,  300, 1'b0, "R5");
        run_point(-0.75,  0.1,  200, 1'b0, "R3");
        run_point(0.3,    0.5,  100, 1'b0, "R3");
        run_point(-0.1,   0.9,  150, 1'b0, "R3");
        run_point(0.5,    0.5,  64,  1'b1, "R8");
        run_point(0.0,    0.0,  30,  1'b1, "R8");
        run_point(2.0,    2.0,  0,   1'b1, "R2");

        repeat (5) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule